// File: doc/BRIEF.md
# Banked SPI Register Access Engine

This block is an SPI master that issues command-level transactions to an attached network controller whose control registers are spread over four banks. A host hands it one operation at a time: read a register, write a register, set or clear bits in a register, stream bytes out of or into the controller's buffer memory, or send the soft-reset command. Along with the operation come a register descriptor byte and a data byte. The engine builds the command byte, drives chip select, shifts the bytes out MSB first and collects the reply from MISO.

The descriptor carries three things. Bits 4:0 are the register address. Bits 6:5 are the bank that holds the register. Bit 7 marks a register that answers one byte late, so a read of it must skip a dummy byte. The engine remembers which bank it last selected. When a register operation names a different bank, or when the host forces a switch, the engine first runs two bit-field transactions on the shared control register at address 0x1F. The first clears the two bank-select bits 1:0 and the second sets the new bank. After that it runs the host's transaction. The host sees one request, a busy flag, an optional per-byte strobe for buffer streams, and a one-cycle done pulse.

Top module: `spi_bank_engine`

## Requirements
- R1: The first byte of every chip-select frame is the 3-bit opcode in bits 7:5 over a 5-bit address in bits 4:0. The opcodes are: register read 0, buffer read 1, register write 2, buffer write 3, bit set 4, bit clear 5, soft reset 7. The two buffer operations always use address 0x1A. Soft reset is the single byte 0xFF.
- R2: A register read sends the command and then 0x00 bytes. If descriptor bit 7 is clear, the frame is two bytes long and rd_data is the second byte clocked in. If bit 7 is set, the frame is three bytes long, the second byte is discarded, and rd_data is the third byte. rd_data is valid when done pulses.
- R3: A register operation (codes 0, 2, 4, 5) whose descriptor bank (bits 6:5) differs from the cached bank is preceded by two frames. The first is 0xBF 0x03 (clear bits 1:0 of register 0x1F). The second is 0x9F followed by the bank value (set). The cache then holds the new bank.
- R4: No bank frames are sent when the descriptor bank equals the cached bank. Buffer operations and soft reset never send bank frames, whatever their descriptor holds.
- R5: With req_force_bank high at the request, the two bank frames are sent even when the bank matches the cache.
- R6: A register write, bit set or bit clear is a two-byte frame: the command byte, then req_data. Chip select is released after it.
- R7: Between chip select falling and the first SCK rise there are at least CS_SETUP_CYC clock cycles.
- R8: SCK is low whenever chip select is high or a byte is not being shifted. Bits go out MSB first. MOSI holds steady while SCK is high. Every frame carries a whole number of bytes.
- R9: A buffer operation is a single frame: the command byte followed by req_len data bytes (req_len 0 sends only the command). On a buffer write, byte_stb is high for one cycle after each clock edge at which stream_wdata was taken for the next data byte. On a buffer read, byte_stb is high for one cycle with rd_data holding each data byte, in the order the bytes were received.
- R10: Chip select stays high for at least 2*CLK_DIV clock cycles between any two frames.
- R11: The bank cache is 0 after reset, and it returns to 0 when a soft-reset transaction completes.
- R12: busy is high from the cycle after a request is accepted until the transaction ends. A request presented while busy is ignored. done is high for exactly one cycle, in the first cycle that busy is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 3 | Operation code |
| req_desc | input | 8 | Register descriptor: bit 7 late-reply class, bits 6:5 bank, bits 4:0 address |
| req_data | input | 8 | Data byte for write, set or clear |
| req_len | input | LEN_W | Number of data bytes for a buffer operation |
| req_force_bank | input | 1 | Force the bank frames for a register operation |
| stream_wdata | input | 8 | Next byte of a buffer write |
| spi_miso | input | 1 | Serial data from the controller |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Register read result or current buffer read byte |
| byte_stb | output | 1 | Per-byte strobe for buffer streams |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the controller |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The results come due at different cycles. busy is sampled on the first falling clock edge after the accepting edge. rd_data is sampled when done is seen, which is 2*CLK_DIV cycles after chip select rises on the last frame. The next falling edge must show done low again, with the bus idle. On the wire, the bench decodes bytes on the falling clock edge that first shows SCK high, and it drives MISO only while SCK is low, so the engine's sampling edge always sees a stable bit. Setup and gap spans are counted in cycles from the chip-select edge, and each is checked at the moment it ends. Buffer stream bytes are matched against byte_stb on the cycle the strobe is seen.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

  typedef enum logic [2:0] {
    OPC_REG_RD  = 3'd0,
    OPC_BUF_RD  = 3'd1,
    OPC_REG_WR  = 3'd2,
    OPC_BUF_WR  = 3'd3,
    OPC_BIT_SET = 3'd4,
    OPC_BIT_CLR = 3'd5,
    OPC_RSV     = 3'd6,
    OPC_RESET   = 3'd7
  } opc_e;

  typedef enum logic [1:0] {FR_BCLR, FR_BSET, FR_MAIN} frame_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_XFER, ST_GAP} state_e;

  localparam logic [4:0] CTRL_ADDR = 5'h1F;
  localparam logic [4:0] BUF_ADDR  = 5'h1A;
  localparam logic [7:0] BANK_MASK = 8'h03;

  function automatic logic is_banked(opc_e op);
    return (op == OPC_REG_RD) || (op == OPC_REG_WR) ||
           (op == OPC_BIT_SET) || (op == OPC_BIT_CLR);
  endfunction

  function automatic logic [7:0] cmd_byte(opc_e op, logic [4:0] addr);
    logic [4:0] a;
    case (op)
      OPC_BUF_RD, OPC_BUF_WR: a = BUF_ADDR;
      OPC_RSV, OPC_RESET:     a = 5'h1F;
      default:                a = addr;
    endcase
    return {op, a};
  endfunction

  // Byte placed on MOSI for a given frame and position.
  function automatic logic [7:0] wire_byte(frame_e fr, logic first, opc_e op,
                                           logic [4:0] addr, logic [1:0] bank,
                                           logic [7:0] wr, logic [7:0] strm);
    logic [7:0] b;
    case (fr)
      FR_BCLR: b = first ? {OPC_BIT_CLR, CTRL_ADDR} : BANK_MASK;
      FR_BSET: b = first ? {OPC_BIT_SET, CTRL_ADDR} : {6'd0, bank};
      default: begin
        if (first)                    b = cmd_byte(op, addr);
        else if (op == OPC_BUF_WR)    b = strm;
        else if (op == OPC_REG_RD ||
                 op == OPC_BUF_RD)    b = 8'h00;
        else                          b = wr;
      end
    endcase
    return b;
  endfunction

endpackage

// File: rtl/sbe_byte_shifter.sv
module sbe_byte_shifter #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic          active, phase;
  logic [DW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  logic phase_end, rise_ev;
  assign phase_end = active && (cnt == DW'(HALF_DIV - 1));
  assign rise_ev   = phase_end && !phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      rx     <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        phase  <= 1'b0;
        cnt    <= '0;
        bitn   <= '0;
        sh     <= tx;
      end else if (active) begin
        if (phase_end) begin
          cnt   <= '0;
          phase <= ~phase;
          if (rise_ev) begin
            rx <= {rx[6:0], miso};
          end else begin
            sh   <= {sh[6:0], 1'b0};
            bitn <= bitn + 3'd1;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end
          end
        end else begin
          cnt <= cnt + DW'(1);
        end
      end
    end
  end

  assign sck  = phase;
  assign mosi = sh[7];

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi)); // R8
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active); // R8

endmodule

// File: rtl/sbe_bank_tracker.sv
module sbe_bank_tracker import sbe_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  opc_e       op,
  input  logic [1:0] bank_req,
  input  logic       force_sw,
  input  logic       commit_set,
  input  logic [1:0] commit_bank,
  input  logic       commit_clr,
  output logic [1:0] bank_q,
  output logic       need_switch
);
  always_comb need_switch = is_banked(op) && (force_sw || (bank_req != bank_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          bank_q <= 2'd0;
    else if (commit_clr) bank_q <= 2'd0;
    else if (commit_set) bank_q <= commit_bank;
  end

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_set && commit_clr)); // R11

endmodule

// File: rtl/spi_bank_engine.sv
module spi_bank_engine import sbe_pkg::*; #(
  parameter int unsigned CLK_DIV      = 2,
  parameter int unsigned CS_SETUP_CYC = 25,
  parameter int unsigned LEN_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [7:0]       req_desc,
  input  logic [7:0]       req_data,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_force_bank,
  input  logic [7:0]       stream_wdata,
  input  logic             spi_miso,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rd_data,
  output logic             byte_stb,
  output logic             spi_sck,
  output logic             spi_mosi,
  output logic             spi_cs_n
);
  localparam int unsigned GAP_CYC = 2 * CLK_DIV;
  localparam int unsigned AGE_MAX = CS_SETUP_CYC + GAP_CYC;
  localparam int unsigned TW      = $clog2(AGE_MAX + 1);
  localparam int unsigned CNT_W   = LEN_W + 1;

  state_e           st;
  frame_e           fr;
  opc_e             op_q;
  logic [7:0]       desc_q, data_q;
  logic [LEN_W-1:0] len_q;
  logic [TW-1:0]    tmr;
  logic [CNT_W-1:0] bidx, last_idx;
  logic             sh_start, sh_done;
  logic [7:0]       sh_tx, sh_rx;
  logic [1:0]       bank_q;
  logic             need_switch, commit_set, commit_clr;
  logic             timer_hit_setup, timer_hit_gap;

  opc_e req_opc;
  assign req_opc = opc_e'(req_op);

  sbe_bank_tracker u_bank (
    .clk(clk), .rst_n(rst_n), .op(req_opc), .bank_req(req_desc[6:5]),
    .force_sw(req_force_bank), .commit_set(commit_set),
    .commit_bank(desc_q[6:5]), .commit_clr(commit_clr),
    .bank_q(bank_q), .need_switch(need_switch)
  );

  sbe_byte_shifter #(.HALF_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .miso(spi_miso),
    .sck(spi_sck), .mosi(spi_mosi), .done(sh_done), .rx(sh_rx)
  );

  // Index of the final byte in the current frame.
  always_comb begin
    if (fr != FR_MAIN) last_idx = CNT_W'(1);
    else begin
      case (op_q)
        OPC_REG_RD:             last_idx = desc_q[7] ? CNT_W'(2) : CNT_W'(1);
        OPC_BUF_RD, OPC_BUF_WR: last_idx = CNT_W'(len_q);
        OPC_RSV, OPC_RESET:     last_idx = '0;
        default:                last_idx = CNT_W'(1);
      endcase
    end
  end

  assign timer_hit_setup = (tmr == TW'(CS_SETUP_CYC - 1));
  assign timer_hit_gap   = (tmr == TW'(GAP_CYC - 1));
  assign commit_set = (st == ST_GAP) && timer_hit_gap && (fr == FR_BSET);
  assign commit_clr = (st == ST_GAP) && timer_hit_gap && (fr == FR_MAIN) &&
                      (op_q == OPC_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  fr <= FR_MAIN;  op_q <= OPC_REG_RD;
      desc_q <= '0;  data_q <= '0;  len_q <= '0;  tmr <= '0;  bidx <= '0;
      sh_start <= 1'b0;  sh_tx <= '0;  spi_cs_n <= 1'b1;
      done <= 1'b0;  rd_data <= '0;  byte_stb <= 1'b0;
    end else begin
      sh_start <= 1'b0;
      done     <= 1'b0;
      byte_stb <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          op_q <= req_opc;  desc_q <= req_desc;  data_q <= req_data;  len_q <= req_len;
          fr <= need_switch ? FR_BCLR : FR_MAIN;
          st <= ST_SETUP;  tmr <= '0;  spi_cs_n <= 1'b0;
        end
        ST_SETUP: begin
          if (timer_hit_setup) begin
            st <= ST_XFER;  bidx <= '0;  sh_start <= 1'b1;
            sh_tx <= wire_byte(fr, 1'b1, op_q, desc_q[4:0], desc_q[6:5], data_q, stream_wdata);
          end else tmr <= tmr + TW'(1);
        end
        ST_XFER: if (sh_done) begin
          if (fr == FR_MAIN && bidx != '0) begin
            if (op_q == OPC_REG_RD && bidx == last_idx) rd_data <= sh_rx;
            if (op_q == OPC_BUF_RD) begin
              rd_data <= sh_rx;  byte_stb <= 1'b1;
            end
          end
          if (bidx == last_idx) begin
            spi_cs_n <= 1'b1;  st <= ST_GAP;  tmr <= '0;
          end else begin
            bidx <= bidx + CNT_W'(1);  sh_start <= 1'b1;
            sh_tx <= wire_byte(fr, 1'b0, op_q, desc_q[4:0], desc_q[6:5], data_q, stream_wdata);
            if (fr == FR_MAIN && op_q == OPC_BUF_WR) byte_stb <= 1'b1;
          end
        end
        ST_GAP: begin
          if (timer_hit_gap) begin
            tmr <= '0;
            if (fr == FR_MAIN) begin
              st <= ST_IDLE;  done <= 1'b1;
            end else begin
              fr <= (fr == FR_BCLR) ? FR_BSET : FR_MAIN;
              st <= ST_SETUP;  spi_cs_n <= 1'b0;
            end
          end else tmr <= tmr + TW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st != ST_IDLE);

  // Chip-select age counters, kept only for the timing assertions.
  logic [TW-1:0] cs_lo_age, cs_hi_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_lo_age <= '0;
      cs_hi_age <= TW'(AGE_MAX);
    end else begin
      cs_lo_age <= spi_cs_n ? '0 : ((cs_lo_age == TW'(AGE_MAX)) ? cs_lo_age : cs_lo_age + TW'(1));
      cs_hi_age <= !spi_cs_n ? '0 : ((cs_hi_age == TW'(AGE_MAX)) ? cs_hi_age : cs_hi_age + TW'(1));
    end
  end

  AST_CS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> (cs_lo_age >= TW'(CS_SETUP_CYC))); // R7
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (cs_hi_age >= TW'(GAP_CYC))); // R10
  AST_SCK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n); // R8
  AST_BANK_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XFER && fr == FR_MAIN && is_banked(op_q)) |-> (bank_q == desc_q[6:5])); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R12

endmodule

// File: tb/spi_bank_engine_tb.sv
module spi_bank_engine_tb;
  localparam int DIV = 2;
  localparam int SETUP = 25;
  localparam int GAP = 2 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [7:0] req_desc = '0, req_data = '0, req_len = '0, stream_wdata = '0;
  logic req_force_bank = 1'b0;
  logic spi_miso = 1'b0;
  logic busy, done, byte_stb, spi_sck, spi_mosi, spi_cs_n;
  logic [7:0] rd_data;

  always #2 clk = ~clk;

  spi_bank_engine #(.CLK_DIV(DIV), .CS_SETUP_CYC(SETUP), .LEN_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_desc(req_desc), .req_data(req_data), .req_len(req_len),
    .req_force_bank(req_force_bank), .stream_wdata(stream_wdata),
    .spi_miso(spi_miso), .busy(busy), .done(done), .rd_data(rd_data),
    .byte_stb(byte_stb), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  int checks = 0, errors = 0, cyc = 0;
  int mbank = 0;
  byte unsigned got_b[$], exp_b[$], cur_fr[$], wq[$];
  int got_n[$], exp_n[$];

  function automatic logic [7:0] resp(int i);
    return 8'(8'hC3 + i * 29);
  endfunction

  task automatic fail(string req, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Behavioural SPI slave and per-cycle bus rules.
  int lo_cnt = 0, hi_cnt = 1000, bitc = 0, bidx = 0;
  bit seen_rise = 0, prev_sck = 0, prev_mosi = 0, prev_cs = 1;
  logic [7:0] cur = '0;
  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fail("WATCHDOG", "cycles", cyc, 150000);
      finish_run();
    end
    if (!spi_cs_n) begin
      if (prev_cs) begin
        checks++;
        if (hi_cnt < GAP) fail("R10", "cs high gap", hi_cnt, GAP);
        lo_cnt = 0; seen_rise = 0; bitc = 0; bidx = 0; cur_fr.delete();
      end
      if (spi_sck && !prev_sck) begin
        if (!seen_rise) begin
          checks++;
          if (lo_cnt < SETUP) fail("R7", "cs setup", lo_cnt, SETUP);
          seen_rise = 1;
        end
        cur = {cur[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
          cur_fr.push_back(cur); bitc = 0; bidx++;
        end
      end
      if (spi_sck && prev_sck && spi_mosi != prev_mosi) begin
        checks++;
        fail("R8", "mosi moved while sck high", spi_mosi, prev_mosi);
      end
      if (!spi_sck) spi_miso = resp(bidx)[7 - bitc];
      lo_cnt++;
    end else begin
      if (!prev_cs) begin
        checks++;
        if (bitc != 0) fail("R8", "partial byte bits", bitc, 0);
        got_n.push_back(cur_fr.size());
        foreach (cur_fr[i]) got_b.push_back(cur_fr[i]);
        hi_cnt = 0;
      end
      if (spi_sck) begin
        checks++;
        fail("R8", "sck while cs high", 1, 0);
      end
      hi_cnt++;
    end
    prev_sck = spi_sck; prev_mosi = spi_mosi; prev_cs = spi_cs_n;
  end

  task automatic expect_frame(byte unsigned b[$]);
    exp_n.push_back(b.size());
    foreach (b[i]) exp_b.push_back(b[i]);
  endtask

  task automatic compare_frames(string req);
    checks++;
    if (got_n.size() != exp_n.size()) fail(req, "frame count", got_n.size(), exp_n.size());
    else begin
      bit bad = 0;
      foreach (exp_n[i]) if (!bad && got_n[i] != exp_n[i]) begin
        fail(req, $sformatf("frame %0d length", i), got_n[i], exp_n[i]); bad = 1;
      end
      if (!bad) foreach (exp_b[i]) if (!bad && got_b[i] != exp_b[i]) begin
        fail(req, $sformatf("wire byte %0d", i), got_b[i], exp_b[i]); bad = 1;
      end
    end
    got_n.delete(); got_b.delete(); exp_n.delete(); exp_b.delete();
  endtask

  task automatic run_op(input int op, input logic [7:0] desc, input logic [7:0] data,
                        input int len, input bit frc, input bit inject, input string req);
    bit banked = (op == 0 || op == 2 || op == 4 || op == 5);
    byte unsigned fb[$];
    int k = 0;
    int guard = 0;
    // Expected frames (R1, R3, R4, R5, R6, R9, R11)
    if (banked && (frc || int'(desc[6:5]) != mbank)) begin
      fb = '{8'hBF, 8'h03}; expect_frame(fb);
      fb = '{8'h9F, 8'(desc[6:5])}; expect_frame(fb);
      mbank = int'(desc[6:5]);
    end
    fb.delete();
    case (op)
      0: begin fb.push_back({3'd0, desc[4:0]}); fb.push_back(8'h00); if (desc[7]) fb.push_back(8'h00); end
      1: begin fb.push_back(8'h3A); for (int i = 0; i < len; i++) fb.push_back(8'h00); end
      3: begin fb.push_back(8'h7A); for (int i = 0; i < len; i++) fb.push_back(wq[i]); end
      7: begin fb.push_back(8'hFF); mbank = 0; end
      default: begin fb.push_back({3'(op), desc[4:0]}); fb.push_back(data); end
    endcase
    expect_frame(fb);
    if (op == 3 && len > 0) stream_wdata = wq[0];
    @(negedge clk);
    req_op = 3'(op); req_desc = desc; req_data = data; req_len = 8'(len);
    req_force_bank = frc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_force_bank = 1'b0;
    checks++;
    if (busy !== 1'b1) fail("R12", "busy after accept", busy, 1);
    while (done !== 1'b1) begin
      guard++;
      if (inject && guard == 40) begin
        req_op = 3'd2; req_desc = 8'h1F; req_data = 8'h77; req_valid = 1'b1;
      end else req_valid = 1'b0;
      if (byte_stb) begin
        if (op == 3) begin
          k++;
          if (k < len) stream_wdata = wq[k];
        end else if (op == 1) begin
          checks++;
          if (rd_data !== resp(k + 1)) fail("R9", "buffer read byte", rd_data, resp(k + 1));
          k++;
        end
      end
      if (guard > 20000) begin
        checks++; fail(req, "no done", 0, 1); finish_run();
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    checks++;
    if (busy !== 1'b0) fail("R12", "busy at done", busy, 0);
    if (op == 0) begin
      checks++;
      if (rd_data !== resp(desc[7] ? 2 : 1)) fail("R2", "register read data", rd_data, resp(desc[7] ? 2 : 1));
    end
    if (op == 1 || op == 3) begin
      checks++;
      if (k != len) fail("R9", "stream strobes", k, len);
    end
    compare_frames(req);
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || busy !== 1'b0 || spi_cs_n !== 1'b1)
      fail("R12", "single done and idle after", {done, busy, spi_cs_n}, 3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R8, R12)
    checks++;
    if (spi_cs_n !== 1'b1 || spi_sck !== 1'b0 || busy !== 1'b0 || done !== 1'b0)
      fail("R12", "reset outputs", {spi_cs_n, spi_sck, busy, done}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_op(2, 8'h05, 8'hA5, 0, 0, 0, "R6");     // bank 0 matches reset cache: R11, R4
    run_op(0, 8'h45, 8'h00, 0, 0, 0, "R3");     // switch to bank 2
    run_op(0, 8'hC7, 8'h00, 0, 0, 0, "R2");     // late-reply register, same bank
    run_op(4, 8'h41, 8'h0C, 0, 1, 0, "R5");     // forced switch, same bank
    run_op(5, 8'h3F, 8'h30, 0, 0, 0, "R3");     // switch to bank 1
    run_op(1, 8'h60, 8'h00, 5, 0, 0, "R4");     // buffer read ignores descriptor bank
    wq = '{8'h11, 8'hE2, 8'h5D, 8'h80};
    run_op(3, 8'h40, 8'h00, 4, 0, 1, "R9");     // buffer write, request injected while busy
    run_op(1, 8'h00, 8'h00, 0, 0, 0, "R9");     // zero-length buffer read
    run_op(7, 8'h00, 8'h00, 0, 0, 0, "R1");     // soft reset
    run_op(2, 8'h10, 8'h3C, 0, 0, 0, "R11");    // cache back at bank 0, no switch
    run_op(2, 8'h3A, 8'h99, 0, 0, 0, "R3");     // bank 1 again
    finish_run();
  end
endmodule